// File: doc/BRIEF.md
# Immediate-Operand ALU Instruction Executor

This block carries out one family of 16-bit instructions. Each of these pairs one of eight low registers with an unsigned 8-bit constant. It holds its own file of eight 32-bit registers and a four-bit condition-flag register. Each clock cycle it may receive one instruction word together with a valid strobe. When the word belongs to the family, the block performs a load-constant, compare, add or subtract operation. It writes the result back when the operation calls for it, and it refreshes the flags.

A valid word from any other family is reported on a one-cycle "unhandled" output and changes nothing. A debug read port returns the content of any register and the current flags, so a testbench or a surrounding core can observe state. Fetch, pipelining, memory access and exceptions belong to other blocks.

Top module: `imm_exec`

## Requirements
- R1: A valid word is recognised only when bits [15:13] equal 3'b001. A valid word with any other value in those bits raises `unhandled` in the cycle after the accepting clock edge and leaves every register and flag unchanged.
- R2: Operation code 0 in bits [12:11] loads the zero-extended 8-bit constant from bits [7:0] into the register named by bits [10:8]. N takes bit 31 of the result, Z is set when the result is zero, and C and V keep their previous values.
- R3: Operation code 2 stores Rd + constant in Rd. N and Z follow the result, C is the carry out of bit 31, and V is 32-bit signed overflow.
- R4: Operation code 3 stores Rd - constant in Rd. N and Z follow the result, C is 1 when no borrow occurs (Rd >= constant as unsigned numbers), and V is 32-bit signed overflow.
- R5: Operation code 1 computes Rd - constant and updates N, Z, C and V exactly as R4 does, but it leaves every register unchanged.
- R6: A write changes only the register named in bits [10:8]. The other seven registers keep their values.
- R7: A synchronous reset clears all eight registers, all four flags and `unhandled` to zero.
- R8: While `instr_valid` is low, no register, no flag and no `unhandled` pulse changes, whatever the instruction word holds.
- R9: A recognised word never raises `unhandled`. The output is registered and stays high only for the cycle that follows each unrecognised valid word.
- R10: `dbg_flags` presents the flags as {N, Z, C, V} from bit 3 down to bit 0. `dbg_data` returns, without delay, the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| unhandled | output | 1 | One-cycle pulse for an unrecognised valid word |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 32 | Content of the selected register |
| dbg_flags | output | 4 | Flags {N, Z, C, V} |

## Verification
The bench targets carry and borrow at the ends of the range. Subtracting 145 from zero must clear C and set N. Adding 1 to all-ones must wrap to zero with C set. A design that inverts the borrow sense, or drops the carry out, gives the wrong C in these cases.

It checks that a compare leaves its register intact even when the difference is zero. It checks that a load of zero keeps an earlier C set, which catches a design that clears C and V on every operation. It checks that words with other top bits, and matching words sent without a strobe, leave state alone, which catches a decoder that looks at too few bits. A final sweep over all registers finds writes that land on the wrong index.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  localparam int DW     = 32;
  localparam int IMM_W  = 8;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {OP_MOV = 2'd0, OP_CMP = 2'd1, OP_ADD = 2'd2, OP_SUB = 2'd3} op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic [DW-1:0] res;
    flags_t        fl;
    logic          wr;
  } alu_out_t;

  function automatic logic [DW-1:0] zext_imm(input logic [IMM_W-1:0] imm);
    return {{(DW-IMM_W){1'b0}}, imm};
  endfunction

  function automatic alu_out_t alu_eval(input op_e op, input logic [DW-1:0] a,
                                        input logic [IMM_W-1:0] imm, input flags_t prev);
    alu_out_t      o;
    logic [DW:0]   wide;
    logic [DW-1:0] b;
    b    = zext_imm(imm);
    wide = '0;
    o    = '0;
    o.fl = prev;
    o.wr = 1'b1;
    case (op)
      OP_MOV: o.res = b;
      OP_ADD: begin
        wide    = {1'b0, a} + {1'b0, b};
        o.res   = wide[DW-1:0];
        o.fl.c  = wide[DW];
        o.fl.v  = (~a[DW-1] & ~b[DW-1] & o.res[DW-1]) | (a[DW-1] & b[DW-1] & ~o.res[DW-1]);
      end
      default: begin
        wide    = {1'b0, a} - {1'b0, b};
        o.res   = wide[DW-1:0];
        o.fl.c  = ~wide[DW];
        o.fl.v  = (a[DW-1] ^ b[DW-1]) & (o.res[DW-1] ^ a[DW-1]);
        o.wr    = (op != OP_CMP);
      end
    endcase
    o.fl.n = o.res[DW-1];
    o.fl.z = (o.res == '0);
    return o;
  endfunction
endpackage

// File: rtl/imm_decode.sv
module imm_decode
  import imm_alu_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic              miss,
  output op_e               op,
  output logic [RIDX_W-1:0] rd,
  output logic [IMM_W-1:0]  imm
);
  localparam logic [2:0] FMT_TAG = 3'b001;

  logic fmt_ok;
  assign fmt_ok = (word[WORD_W-1:WORD_W-3] == FMT_TAG);
  assign hit    = valid & fmt_ok;
  assign miss   = valid & ~fmt_ok;
  assign op     = op_e'(word[12:11]);
  assign rd     = word[IMM_W +: RIDX_W];
  assign imm    = word[IMM_W-1:0];
endmodule

// File: rtl/imm_regfile.sv
module imm_regfile
  import imm_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RIDX_W-1:0]  widx,
  input  logic [DW-1:0]      wdata,
  input  logic [RIDX_W-1:0]  aidx,
  output logic [DW-1:0]      adata,
  input  logic [RIDX_W-1:0]  bidx,
  output logic [DW-1:0]      bdata,
  output logic [NREG*DW-1:0] flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                    q <= '0;
      else if (we && widx == RIDX_W'(i))          q <= wdata;
    end
    assign flat[i*DW +: DW] = q;
  end

  assign adata = flat[aidx*DW +: DW];
  assign bdata = flat[bidx*DW +: DW];
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
(
  input  op_e              op,
  input  logic [DW-1:0]    a,
  input  logic [IMM_W-1:0] imm,
  input  flags_t           prev,
  output logic [DW-1:0]    res,
  output flags_t           fl,
  output logic             wr
);
  alu_out_t o;
  always_comb o = alu_eval(op, a, imm, prev);
  assign res = o.res;
  assign fl  = o.fl;
  assign wr  = o.wr;
endmodule

// File: rtl/imm_exec.sv
module imm_exec
  import imm_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  input  logic [15:0] instr_word,
  output logic        unhandled,
  input  logic [2:0]  dbg_sel,
  output logic [31:0] dbg_data,
  output logic [3:0]  dbg_flags
);
  logic              hit, miss, alu_wr, wr_fire;
  op_e               op;
  logic [RIDX_W-1:0] rd;
  logic [IMM_W-1:0]  imm;
  logic [DW-1:0]     rd_val, alu_res;
  flags_t            flags_q, alu_fl;
  logic [NREG*DW-1:0] reg_flat;

  imm_decode u_dec (
    .valid(instr_valid), .word(instr_word), .hit(hit), .miss(miss),
    .op(op), .rd(rd), .imm(imm)
  );

  imm_alu u_alu (
    .op(op), .a(rd_val), .imm(imm), .prev(flags_q),
    .res(alu_res), .fl(alu_fl), .wr(alu_wr)
  );

  assign wr_fire = hit & alu_wr;

  imm_regfile u_rf (
    .clk(clk), .rst(rst), .we(wr_fire), .widx(rd), .wdata(alu_res),
    .aidx(rd), .adata(rd_val), .bidx(dbg_sel), .bdata(dbg_data), .flat(reg_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      unhandled <= 1'b0;
    end else begin
      unhandled <= miss;
      if (hit) flags_q <= alu_fl;
    end
  end

  assign dbg_flags = flags_q;
endmodule

// File: rtl/imm_exec_chk.sv
module imm_exec_chk (
  input logic         clk,
  input logic         rst,
  input logic         instr_valid,
  input logic [15:0]  instr_word,
  input logic         unhandled,
  input logic [3:0]   flags_q,
  input logic [255:0] reg_flat
);
  logic match;
  assign match = (instr_word[15:13] == 3'b001);

  // R1
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !match) |=> (unhandled && $stable(flags_q) && $stable(reg_flat)));

  // R9
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && match) |=> !unhandled);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!unhandled && $stable(flags_q) && $stable(reg_flat)));

  // R5
  cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && match && instr_word[12:11] == 2'd1) |=> $stable(reg_flat));

  // R2
  mov_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && match && instr_word[12:11] == 2'd0) |=> (flags_q[1:0] == $past(flags_q[1:0])));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_flat == '0 && flags_q == 4'd0 && !unhandled));
endmodule

bind imm_exec imm_exec_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .unhandled(unhandled), .flags_q(dbg_flags), .reg_flat(reg_flat)
);

// File: tb/imm_exec_test.sv
module imm_exec_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {word, expected Rd value, expected {N,Z,C,V}, expected unhandled}
  localparam logic [52:0] VEC [NV] = '{
    {16'h2080, 32'h0000_0080, 4'b0000, 1'b0},
    {16'h31FF, 32'h0000_00FF, 4'b0000, 1'b0},
    {16'h3E91, 32'hFFFF_FF6F, 4'b1000, 1'b0},
    {16'h2A3E, 32'h0000_0000, 4'b1000, 1'b0},
    {16'h2880, 32'h0000_0080, 4'b0110, 1'b0},
    {16'h2300, 32'h0000_0000, 4'b0110, 1'b0},
    {16'h2405, 32'h0000_0005, 4'b0010, 1'b0},
    {16'h3C05, 32'h0000_0000, 4'b0110, 1'b0},
    {16'h4C05, 32'h0000_0000, 4'b0110, 1'b1},
    {16'h0000, 32'h0000_0080, 4'b0110, 1'b1},
    {16'h3691, 32'h0000_0000, 4'b0110, 1'b0},
    {16'h3F01, 32'hFFFF_FFFF, 4'b1000, 1'b0},
    {16'h3701, 32'h0000_0000, 4'b0110, 1'b0},
    {16'h2910, 32'h0000_00FF, 4'b0010, 1'b0},
    {16'hFFFF, 32'h0000_0000, 4'b0010, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [2:0]  dbg_sel = '0;
  logic        unhandled;
  logic [31:0] dbg_data;
  logic [3:0]  dbg_flags;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_exec uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .unhandled(unhandled), .dbg_sel(dbg_sel), .dbg_data(dbg_data), .dbg_flags(dbg_flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] w);
    if (w[15:13] != 3'b001) return "R1";
    case (w[12:11])
      2'd0: return "R2";
      2'd1: return "R5";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    check("R7 flags", 32'(dbg_flags), 32'h0);
    check("R7 unhandled", 32'(unhandled), 32'h0);
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i);
      #1 check("R7 reg", dbg_data, 32'h0);
    end

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = VEC[k][52:37];
      dbg_sel     = VEC[k][47:45];
      @(negedge clk);
      instr_valid = 1'b0;
      check({tag_of(VEC[k][52:37]), " value"}, dbg_data, VEC[k][36:5]);
      check({tag_of(VEC[k][52:37]), " R10 flags"}, 32'(dbg_flags), 32'(VEC[k][4:1]));
      check(VEC[k][0] ? "R1 unhandled" : "R9 unhandled", 32'(unhandled), 32'(VEC[k][0]));
    end

    // R9: pulse lasts one cycle
    @(negedge clk);
    check("R9 pulse end", 32'(unhandled), 32'h0);

    // R6: register sweep
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i);
      #1 check("R6 sweep", dbg_data, i == 0 ? 32'h80 : (i == 1 ? 32'hFF : 32'h0));
    end

    // R8: matching word without strobe
    instr_word = 16'h2755;
    dbg_sel    = 3'd7;
    @(negedge clk);
    @(negedge clk);
    check("R8 reg", dbg_data, 32'h0);
    check("R8 flags", 32'(dbg_flags), 32'h2);
    check("R8 unhandled", 32'(unhandled), 32'h0);

    // R7: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    dbg_sel = 3'd1;
    #1 check("R7 mid reg", dbg_data, 32'h0);
    check("R7 mid flags", 32'(dbg_flags), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule